// File: doc/BRIEF.md
# Pipelined CORDIC Vector Rotator

This block turns a two's-complement vector (X, Y) through a signed angle using the shift-and-add CORDIC method in rotation mode. The iterations are fully unrolled, so each has its own stage. Stage i always runs iteration i. Its shifts are fixed at i bits, which makes them plain wiring, and its arctangent step is a constant computed when the design is built. There is no control state machine and no shared shifter or lookup table. A valid flag travels beside the data through a shift line, so a new sample can enter on every clock and one result leaves on every clock after a fixed latency.

Angles use a binary-turn encoding. The `in_ang` port is signed, and 2^ANG_W units make one full turn, so +2^(ANG_W-2) is +90 degrees and -2^(ANG_W-2) is -90 degrees. The outputs carry the CORDIC gain K = prod over i < N_ITER of sqrt(1 + 2^-2i), which is about 1.6468. The block does not remove this gain. The outputs are two bits wider than the inputs so that the gain and the vector length fit without wrapping. Gain removal, vectoring mode and folding of angles beyond the convergence range are left to the surrounding logic.

Top module: `cordic_rot_pipe`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid` is 0 and `out_x`, `out_y` and `out_ang` are all 0.
- R2: A sample captured at rising edge k appears on the outputs, with `out_valid` high, right after rising edge k+N_ITER-1. The data passes N_ITER register levels, and the capturing edge counts as the first.
- R3: Samples presented with `in_valid` high on consecutive cycles each produce their own result on consecutive cycles, with no stall or gap.
- R4: `out_valid` repeats the `in_valid` pattern, delayed by the latency of R2. A cycle with `in_valid` low never yields `out_valid` high, whatever data it carries.
- R5: For |angle| up to 90 degrees, `out_x` equals K*(x*cos t - y*sin t) and `out_y` equals K*(x*sin t + y*cos t), each within 10 LSB at the default parameters. Here t = in_ang*2*pi/2^ANG_W.
- R6: Each stage turns counterclockwise and lowers its angle register when that register is non-negative (sign bit 0). Otherwise it turns clockwise and raises the angle register. A positive angle applied to a vector on the +X axis gives a positive `out_y`, and a negative angle gives a negative `out_y`.
- R7: The leftover angle `out_ang` has a magnitude of at most 2*atan(2^-(N_ITER-1)) in turn units plus N_ITER. Inside every stage, an angle with magnitude at most twice that stage's step leaves the stage with magnitude at most one step.
- R8: Negative X and Y inputs are rotated correctly. The per-stage shifts are arithmetic and keep the sign.
- R9: Full-scale inputs, including (-2^(DATA_W-1), -2^(DATA_W-1)), rotated by +/-90 degrees still meet R5. No stage or output wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks the input sample as valid this cycle |
| in_x | input | DATA_W | Input X, signed |
| in_y | input | DATA_W | Input Y, signed |
| in_ang | input | ANG_W | Rotation angle, signed, 2^ANG_W units per turn |
| out_valid | output | 1 | Marks the output sample as valid |
| out_x | output | DATA_W+2 | Rotated X, signed, scaled by K |
| out_y | output | DATA_W+2 | Rotated Y, signed, scaled by K |
| out_ang | output | ANG_W | Leftover angle after the last stage |

## Verification
The main rotation is swept over 129 angles evenly spaced from -90 to +90 degrees, applied to vectors on each axis in both directions, to mixed-sign vectors, to a tiny vector and to both full-scale diagonals. The axis vectors separate errors in the X and Y add/subtract senses. The negative and diagonal vectors expose logical (non-arithmetic) shifts and width wrap. A single isolated pulse pins down the exact latency. Pure +X inputs at +/-45 degrees tell a correct direction rule from an inverted one. A burst in which every third cycle is invalid and carries junk data shows that the valid line is neither shifted nor leaking. Each valid result is compared with a real-valued rotation scaled by the gain, and its leftover angle is checked against the bound.

// File: rtl/cordic_rot_pkg.sv
package cordic_rot_pkg;

    // atan(2^-i) as a fraction of one full turn, scaled by 2^32
    function automatic longint unsigned atan_turn32(input int idx);
        case (idx)
            0:  return 64'h20000000;
            1:  return 64'h12E4051E;
            2:  return 64'h09FB385B;
            3:  return 64'h051111D4;
            4:  return 64'h028B0D43;
            5:  return 64'h0145D7E1;
            6:  return 64'h00A2F61E;
            7:  return 64'h00517C55;
            8:  return 64'h0028BE53;
            9:  return 64'h00145F2F;
            10: return 64'h000A2F98;
            11: return 64'h000517CC;
            12: return 64'h00028BE6;
            13: return 64'h000145F3;
            14: return 64'h0000A2FA;
            15: return 64'h0000517D;
            16: return 64'h000028BE;
            17: return 64'h0000145F;
            18: return 64'h00000A30;
            19: return 64'h00000518;
            20: return 64'h0000028C;
            21: return 64'h00000146;
            22: return 64'h000000A3;
            23: return 64'h00000051;
            24: return 64'h00000029;
            25: return 64'h00000014;
            26: return 64'h0000000A;
            27: return 64'h00000005;
            28: return 64'h00000003;
            29: return 64'h00000001;
            30: return 64'h00000001;
            default: return 64'h0;
        endcase
    endfunction

    // Arctangent step rounded to a turn scaled by 2^w
    function automatic longint unsigned atan_units(input int idx, input int w);
        longint unsigned t;
        t = atan_turn32(idx);
        if (w >= 32)
            return t << (w - 32);
        return (t + (64'd1 << (31 - w))) >> (32 - w);
    endfunction

endpackage

// File: rtl/cordic_valid_line.sv
module cordic_valid_line #(
    parameter int DEPTH = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vin,
    output logic [DEPTH:0]   taps
);
    // sr[k] holds the flag delayed by k+1 cycles
    logic [DEPTH-1:0] sr;

    always_ff @(posedge clk) begin
        if (!rst_n)
            sr <= '0;
        else
            sr <= (sr << 1) | DEPTH'(vin);
    end

    assign taps = {sr, vin};

endmodule

// File: rtl/cordic_rot_stage.sv
module cordic_rot_stage
    import cordic_rot_pkg::*;
#(
    parameter int XW    = 14,
    parameter int ANG_W = 20,
    parameter int IDX   = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    vld_in,
    input  logic signed [XW-1:0]    x_in,
    input  logic signed [XW-1:0]    y_in,
    input  logic signed [ANG_W-1:0] z_in,
    output logic signed [XW-1:0]    x_out,
    output logic signed [XW-1:0]    y_out,
    output logic signed [ANG_W-1:0] z_out
);
    localparam logic signed [ANG_W-1:0] STEP = ANG_W'(atan_units(IDX, ANG_W));

    logic                    turn_ccw;
    logic signed [XW-1:0]    x_sh, y_sh, x_nx, y_nx;
    logic signed [ANG_W-1:0] z_nx;

    always_comb begin
        turn_ccw = ~z_in[ANG_W-1];
        x_sh     = x_in >>> IDX;
        y_sh     = y_in >>> IDX;
        if (turn_ccw) begin
            x_nx = x_in - y_sh;
            y_nx = y_in + x_sh;
            z_nx = z_in - STEP;
        end else begin
            x_nx = x_in + y_sh;
            y_nx = y_in - x_sh;
            z_nx = z_in + STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_out <= '0;
            y_out <= '0;
            z_out <= '0;
        end else begin
            x_out <= x_nx;
            y_out <= y_nx;
            z_out <= z_nx;
        end
    end

    function automatic logic [ANG_W:0] mag(input logic signed [ANG_W-1:0] v);
        logic signed [ANG_W:0] e;
        e = {v[ANG_W-1], v};
        return (e < 0) ? ANG_W'(0) - e : e;
    endfunction

    AST_DIR_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(vld_in) |-> ($past(z_in[ANG_W-1]) ? (z_out >= $past(z_in)) : (z_out <= $past(z_in)))); // R6

    AST_ANG_CONVERGE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(vld_in && (mag(z_in) <= 2 * mag(STEP))) |-> (mag(z_out) <= mag(STEP))); // R7

endmodule

// File: rtl/cordic_rot_pipe.sv
module cordic_rot_pipe #(
    parameter int DATA_W = 12,
    parameter int ANG_W  = 20,
    parameter int N_ITER = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_x,
    input  logic signed [DATA_W-1:0] in_y,
    input  logic signed [ANG_W-1:0]  in_ang,
    output logic                     out_valid,
    output logic signed [DATA_W+1:0] out_x,
    output logic signed [DATA_W+1:0] out_y,
    output logic signed [ANG_W-1:0]  out_ang
);
    localparam int XW = DATA_W + 2;
    localparam int CW = $clog2(N_ITER + 2) + 1;

    if (N_ITER < 1 || N_ITER > 32) begin : g_bad_depth
        $error("N_ITER must lie in 1..32");
    end

    logic signed [XW-1:0]    xs [N_ITER+1];
    logic signed [XW-1:0]    ys [N_ITER+1];
    logic signed [ANG_W-1:0] zs [N_ITER+1];
    logic [N_ITER:0]         vtap;

    assign xs[0] = XW'(in_x);
    assign ys[0] = XW'(in_y);
    assign zs[0] = in_ang;

    cordic_valid_line #(.DEPTH(N_ITER)) u_vline (
        .clk   (clk),
        .rst_n (rst_n),
        .vin   (in_valid),
        .taps  (vtap)
    );

    for (genvar i = 0; i < N_ITER; i++) begin : g_stage
        cordic_rot_stage #(.XW(XW), .ANG_W(ANG_W), .IDX(i)) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .vld_in (vtap[i]),
            .x_in   (xs[i]),
            .y_in   (ys[i]),
            .z_in   (zs[i]),
            .x_out  (xs[i+1]),
            .y_out  (ys[i+1]),
            .z_out  (zs[i+1])
        );
    end

    assign out_valid = vtap[N_ITER];
    assign out_x     = xs[N_ITER];
    assign out_y     = ys[N_ITER];
    assign out_ang   = zs[N_ITER];

    // Count of samples currently inside the pipe, kept from the port handshake
    logic [CW-1:0] inflight;
    always_ff @(posedge clk) begin
        if (!rst_n)
            inflight <= '0;
        else
            inflight <= inflight + CW'(in_valid) - CW'(out_valid);
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && out_x == 0 && out_y == 0 && out_ang == 0)); // R1

    AST_PIPE_FULL_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (inflight == CW'(N_ITER)) |-> out_valid); // R3

    AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= CW'(N_ITER)); // R4

endmodule

// File: tb/sim_cordic_rot_pipe.sv
module sim_cordic_rot_pipe;
    localparam int    DW    = 12;
    localparam int    AW    = 20;
    localparam int    NI    = 14;
    localparam int    XW    = DW + 2;
    localparam int    TOL   = 10;
    localparam int    DEPTH = 4096;
    localparam real   PI    = 3.14159265358979323846;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_x = '0;
    logic signed [DW-1:0] in_y = '0;
    logic signed [AW-1:0] in_ang = '0;
    logic                 out_valid;
    logic signed [XW-1:0] out_x, out_y;
    logic signed [AW-1:0] out_ang;

    always #2 clk = ~clk;

    cordic_rot_pipe #(.DATA_W(DW), .ANG_W(AW), .N_ITER(NI)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_x(in_x), .in_y(in_y), .in_ang(in_ang),
        .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .out_ang(out_ang)
    );

    int    cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    bit    ev [DEPTH];
    bit    esg [DEPTH];
    real   ex [DEPTH];
    real   ey [DEPTH];
    string etag [DEPTH];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    mon_on = 1'b0;
    real   kgain = 1.0;
    real   rbound;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input bit v, input int x, input int y, input int a,
                         input string tag, input bit sgn);
        int  idx;
        real t;
        @(negedge clk);
        in_valid = v;
        in_x     = x[DW-1:0];
        in_y     = y[DW-1:0];
        in_ang   = a[AW-1:0];
        idx      = (cyc + 1) % DEPTH;
        ev[idx]  = v;
        esg[idx] = sgn;
        etag[idx] = tag;
        t        = real'(a) * 2.0 * PI / real'(2 ** AW);
        ex[idx]  = kgain * (real'(x) * $cos(t) - real'(y) * $sin(t));
        ey[idx]  = kgain * (real'(x) * $sin(t) + real'(y) * $cos(t));
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) drive(1'b0, 0, 0, 0, "idle", 1'b0);
    endtask

    // Output monitor: result for the capture edge cyc-(NI-1)
    always @(negedge clk) begin
        if (mon_on) begin
            int  idx;
            real dx, dy;
            idx = (cyc - (NI - 1) + DEPTH) % DEPTH;
            chk(out_valid == ev[idx], {"R2 R4 valid timing ", etag[idx]}, longint'(out_valid), longint'(ev[idx]));
            if (out_valid && ev[idx]) begin
                dx = real'(out_x) - ex[idx];
                dy = real'(out_y) - ey[idx];
                chk(dx <= TOL && dx >= -TOL, {"R5 out_x ", etag[idx]}, longint'(out_x), longint'($rtoi(ex[idx])));
                chk(dy <= TOL && dy >= -TOL, {"R5 out_y ", etag[idx]}, longint'(out_y), longint'($rtoi(ey[idx])));
                chk(real'(out_ang) <= rbound && real'(out_ang) >= -rbound, "R7 residual angle",
                    longint'(out_ang), longint'($rtoi(rbound)));
                if (esg[idx])
                    chk((out_y > 0) == (ey[idx] > 0.0), "R6 rotation direction sign of out_y",
                        longint'(out_y), longint'($rtoi(ey[idx])));
            end
        end
    end

    initial begin
        #(4 * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    int vx [9] = '{2047, 0, -2048, 0, 1500, -700, -2048, 2047, 5};
    int vy [9] = '{0, 2047, 0, -2048, -900, 1300, -2048, 2047, -3};

    initial begin
        for (int i = 0; i < NI; i++) kgain = kgain * $sqrt(1.0 + 1.0 / real'(4.0 ** i));
        rbound = 2.0 * $atan(1.0 / real'(2.0 ** (NI - 1))) * real'(2 ** AW) / (2.0 * PI) + real'(NI);

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid in reset", longint'(out_valid), 0);
        chk(out_x == 0 && out_y == 0, "R1 out_x/out_y in reset", longint'(out_x), 0);
        chk(out_ang == 0, "R1 out_ang in reset", longint'(out_ang), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && out_x == 0, "R1 first cycle after reset", longint'(out_valid), 0);
        mon_on = 1'b1;
        idle(2);

        // R2: single isolated pulse, exact latency checked by the monitor
        drive(1'b1, 1000, 0, 2 ** (AW - 3), "R2 single pulse", 1'b0);
        idle(NI + 3);

        // R6: direction on +X axis at +/-45 degrees
        drive(1'b1, 2047, 0,  2 ** (AW - 3), "R6 +45", 1'b1);
        drive(1'b1, 2047, 0, -(2 ** (AW - 3)), "R6 -45", 1'b1);
        drive(1'b1, 1200, 0,  2 ** (AW - 4), "R6 +22.5", 1'b1);
        drive(1'b1, 1200, 0, -(2 ** (AW - 4)), "R6 -22.5", 1'b1);
        idle(NI + 2);

        // R3 R5 R8 R9: back-to-back sweep of angles over several vectors
        for (int v = 0; v < 9; v++) begin
            for (int j = -64; j <= 64; j++) begin
                string tg;
                tg = "R3 sweep";
                if (vx[v] < 0 || vy[v] < 0) tg = {tg, " R8 negative"};
                if (v == 6 || v == 7) tg = {tg, " R9 full scale"};
                drive(1'b1, vx[v], vy[v], j * (2 ** (AW - 8)), tg, 1'b0);
            end
        end
        idle(NI + 2);

        // R4: gapped stream, junk data on invalid cycles
        for (int k = 0; k < 240; k++) begin
            if (k % 3 == 1)
                drive(1'b0, (k * 37) % 2048, -((k * 53) % 2048), (k * 7919) % (2 ** (AW - 1)), "R4 gap", 1'b0);
            else
                drive(1'b1, 1800 - k * 9, k * 7 - 900, (k - 120) * 2000, "R4 gapped stream", 1'b0);
        end
        idle(NI + 3);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule